// File: doc/BRIEF.md
# Dithered Paged PWM Generator

This block drives one pulse-width-modulated line from a duty value of `DUTY_W` bits. A full period lasts 2^DUTY_W base clocks, so the fraction of time the line is high equals the duty value divided by 2^DUTY_W. The block does not emit one long pulse per period. It splits the period into 2^N equal windows, where N is a programmable page count, and it shares the high time among those windows. This raises the ripple frequency seen by an external low-pass filter.

Software writes a duty value and a page count through two write strobes. Both values land in holding registers. They pass to the pattern logic only when a new period begins, so a period is never built from a mix of old and new settings. Inside each window the high clocks come first and the low clocks follow. The remainder that does not divide evenly among the windows is handed out one clock at a time, in bit-reversed window order, so the extra clocks are spread evenly across the period.

Top module: `pwm_dither_top`

## Requirements
- R1: Over each full period of 2^DUTY_W clocks, the number of clocks with `pwm_out` high equals the duty value active in that period. A duty of 0 keeps the line low for the whole period.
- R2: With an active page count N, the period is divided into 2^N consecutive windows. Each window is 2^(DUTY_W-N) clocks long, and window w covers period clocks w*2^(DUTY_W-N) through (w+1)*2^(DUTY_W-N)-1.
- R3: Every window is high for at least duty>>N clocks and for at most one clock more than that.
- R4: Window w gets the one extra clock exactly when the N-bit bit reversal of w is less than duty mod 2^N. Bit reversal swaps bit i with bit N-1-i.
- R5: Inside a window, all high clocks come before all low clocks.
- R6: A value written to the duty or page register takes effect at the next period start only, that is, after the period counter wraps from its last value to 0. The period in progress keeps the values it started with.
- R7: A written page count above MAX_PAGE (default 10) is stored as MAX_PAGE.
- R8: While reset is asserted, both holding registers and both active values are 0 and `pwm_out` is low. In the first clock after reset is released, the period counter is at clock 0.
- R9: `pwm_out` is registered. In the cycle after the period counter shows clock c, the line carries the value that R2 to R5 give for clock c.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| duty_wr | input | 1 | Write strobe for the duty holding register |
| duty_in | input | DUTY_W | Duty value to store |
| page_wr | input | 1 | Write strobe for the page-count holding register |
| page_in | input | PAGE_W | Page count to store, clamped to MAX_PAGE |
| pwm_out | output | 1 | Registered PWM line |

## Verification
The line is tried with the following duty and page settings:
- A zero duty, which shows that the line never goes high.
- A single-window odd duty, which checks that one contiguous pulse is produced.
- A duty with a nonzero remainder over sixteen windows, which separates bit-reversed placement of the extra clocks from linear placement.
- A near-full duty at the largest page count, where each window is only a few clocks long.
- Page counts above the limit, which must behave exactly like the limit.

A behavioural model predicts every output clock. Per-period counts of high clocks confirm the overall fraction. Writes issued in the middle of a period show whether new settings wait for the period boundary.

// File: rtl/pwm_dither_pkg.sv
package pwm_dither_pkg;

  // Reverse the lowest n bits of v; bits at and above n come out as zero.
  function automatic logic [31:0] rev_low(input logic [31:0] v, input int unsigned n);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 32; i++) begin
      if (i < int'(n)) r[int'(n) - 1 - i] = v[i];
    end
    return r;
  endfunction

endpackage

// File: rtl/pwm_dither_regs.sv
module pwm_dither_regs #(
  parameter int DUTY_W   = 16,
  parameter int PAGE_W   = 4,
  parameter int MAX_PAGE = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              duty_wr,
  input  logic [DUTY_W-1:0] duty_in,
  input  logic              page_wr,
  input  logic [PAGE_W-1:0] page_in,
  output logic [DUTY_W-1:0] duty_sh,
  output logic [PAGE_W-1:0] page_sh
);
  localparam logic [PAGE_W-1:0] PAGE_LIM = PAGE_W'(MAX_PAGE);

  logic [PAGE_W-1:0] page_clamped;

  always_comb begin
    page_clamped = (page_in > PAGE_LIM) ? PAGE_LIM : page_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_sh <= '0;
      page_sh <= '0;
    end else begin
      if (duty_wr) duty_sh <= duty_in;
      if (page_wr) page_sh <= page_clamped;
    end
  end

  AST_PAGE_CLAMPED: assert property (@(posedge clk) disable iff (rst)
    page_sh <= PAGE_LIM); // R7

endmodule

// File: rtl/pwm_dither_seq.sv
module pwm_dither_seq #(
  parameter int DUTY_W = 16,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DUTY_W-1:0] duty_sh,
  input  logic [PAGE_W-1:0] page_sh,
  output logic [DUTY_W-1:0] cnt,
  output logic [DUTY_W-1:0] duty_act,
  output logic [PAGE_W-1:0] page_act
);
  localparam logic [DUTY_W-1:0] CNT_LAST = '1;

  logic wrap;

  always_comb begin
    wrap = (cnt == CNT_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      duty_act <= '0;
      page_act <= '0;
    end else begin
      cnt <= cnt + 1'b1;
      if (wrap) begin
        duty_act <= duty_sh;
        page_act <= page_sh;
      end
    end
  end

  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |-> ($stable(duty_act) && $stable(page_act))); // R6

endmodule

// File: rtl/pwm_dither_gen.sv
module pwm_dither_gen
  import pwm_dither_pkg::*;
#(
  parameter int DUTY_W = 16,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DUTY_W-1:0] cnt,
  input  logic [DUTY_W-1:0] duty_act,
  input  logic [PAGE_W-1:0] page_act,
  output logic              pwm_out
);
  localparam logic [DUTY_W-1:0] ONES = '1;

  logic [DUTY_W-1:0] win_idx;
  logic [DUTY_W-1:0] offset;
  logic [DUTY_W-1:0] base_hi;
  logic [DUTY_W-1:0] rem_cnt;
  logic [DUTY_W-1:0] win_rev;
  logic              extra;
  logic [DUTY_W:0]   high_len;
  logic              high_now;

  always_comb begin
    win_idx  = cnt >> (DUTY_W - int'(page_act));
    offset   = cnt & (ONES >> page_act);
    base_hi  = duty_act >> page_act;
    rem_cnt  = duty_act & ~(ONES << page_act);
    win_rev  = DUTY_W'(rev_low(32'(win_idx), int'(page_act)));
    extra    = (rem_cnt > win_rev);
    high_len = {1'b0, base_hi} + {{DUTY_W{1'b0}}, extra};
    high_now = ({1'b0, offset} < high_len);
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_out <= 1'b0;
    else     pwm_out <= high_now;
  end

  AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (rst)
    (duty_act == '0) |=> !pwm_out); // R1

  AST_HIGH_BEFORE_LOW: assert property (@(posedge clk) disable iff (rst)
    (!pwm_out && (offset != '0)) |=> !pwm_out); // R5

endmodule

// File: rtl/pwm_dither_top.sv
module pwm_dither_top #(
  parameter int DUTY_W   = 16,
  parameter int PAGE_W   = 4,
  parameter int MAX_PAGE = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              duty_wr,
  input  logic [DUTY_W-1:0] duty_in,
  input  logic              page_wr,
  input  logic [PAGE_W-1:0] page_in,
  output logic              pwm_out
);
  logic [DUTY_W-1:0] duty_sh;
  logic [PAGE_W-1:0] page_sh;
  logic [DUTY_W-1:0] cnt;
  logic [DUTY_W-1:0] duty_act;
  logic [PAGE_W-1:0] page_act;

  pwm_dither_regs #(.DUTY_W(DUTY_W), .PAGE_W(PAGE_W), .MAX_PAGE(MAX_PAGE)) u_regs (
    .clk(clk), .rst(rst),
    .duty_wr(duty_wr), .duty_in(duty_in),
    .page_wr(page_wr), .page_in(page_in),
    .duty_sh(duty_sh), .page_sh(page_sh)
  );

  pwm_dither_seq #(.DUTY_W(DUTY_W), .PAGE_W(PAGE_W)) u_seq (
    .clk(clk), .rst(rst),
    .duty_sh(duty_sh), .page_sh(page_sh),
    .cnt(cnt), .duty_act(duty_act), .page_act(page_act)
  );

  pwm_dither_gen #(.DUTY_W(DUTY_W), .PAGE_W(PAGE_W)) u_gen (
    .clk(clk), .rst(rst),
    .cnt(cnt), .duty_act(duty_act), .page_act(page_act),
    .pwm_out(pwm_out)
  );

endmodule

// File: tb/test_pwm_dither_top.sv
module test_pwm_dither_top;
  localparam int DW   = 10;
  localparam int PW   = 4;
  localparam int MAXP = 8;
  localparam int PER  = 1 << DW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          duty_wr = 1'b0;
  logic [DW-1:0] duty_in = '0;
  logic          page_wr = 1'b0;
  logic [PW-1:0] page_in = '0;
  logic          pwm_out;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string cur_req = "R8";

  always #5 clk = ~clk;

  pwm_dither_top #(.DUTY_W(DW), .PAGE_W(PW), .MAX_PAGE(MAXP)) i_pwm_dither_top (
    .clk(clk), .rst(rst),
    .duty_wr(duty_wr), .duty_in(duty_in),
    .page_wr(page_wr), .page_in(page_in),
    .pwm_out(pwm_out)
  );

  // Expected line value for period clock c (R2, R3, R4, R5)
  function automatic int exp_bit(int c, int d, int p);
    int len, w, o, r, rem;
    len = PER >> p;
    w = c / len;
    o = c % len;
    r = 0;
    for (int i = 0; i < p; i++) if (((w >> i) & 1) != 0) r |= 1 << (p - 1 - i);
    rem = d % (1 << p);
    return (o < (d >> p) + ((rem > r) ? 1 : 0)) ? 1 : 0;
  endfunction

  int m_cnt, act_d, act_p, sh_d, sh_p, m_exp, m_end_duty;
  bit m_end;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; act_d = 0; act_p = 0; sh_d = 0; sh_p = 0; m_exp = 0; m_end = 0;
    end else begin
      m_exp = exp_bit(m_cnt, act_d, act_p);          // R9 one-cycle latency
      m_end = (m_cnt == PER - 1);
      m_end_duty = act_d;
      if (m_end) begin act_d = sh_d; act_p = sh_p; end // R6
      m_cnt = (m_cnt + 1) % PER;
      if (duty_wr) sh_d = int'(duty_in);
      if (page_wr) sh_p = (int'(page_in) > MAXP) ? MAXP : int'(page_in); // R7
    end
  end

  int acc;
  always @(negedge clk) begin
    if (!done) begin
      if (rst) begin
        acc = 0;
        total++;
        if (pwm_out !== 1'b0) begin
          bad++;
          $display("FAIL R8 reset: pwm_out=%b expected 0", pwm_out);
        end
      end else begin
        total++;
        if (pwm_out !== m_exp[0]) begin
          bad++;
          $display("FAIL %s clock %0d: pwm_out=%b expected %0d", cur_req, m_cnt, pwm_out, m_exp);
        end
        acc += (pwm_out === 1'b1) ? 1 : 0;
        if (m_end) begin
          total++;
          if (acc != m_end_duty) begin
            bad++;
            $display("FAIL R1 period high count=%0d expected %0d", acc, m_end_duty);
          end
          acc = 0;
        end
      end
    end
  end

  task automatic wr_duty(int v);
    @(negedge clk); #1 duty_wr = 1'b1; duty_in = DW'(v);
    @(negedge clk); #1 duty_wr = 1'b0;
  endtask

  task automatic wr_page(int v);
    @(negedge clk); #1 page_wr = 1'b1; page_in = PW'(v);
    @(negedge clk); #1 page_wr = 1'b0;
  endtask

  task automatic run_clocks(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    run_clocks(5);
    #1 rst = 1'b0;
    cur_req = "R1";  wr_duty(0);   wr_page(3);  run_clocks(2 * PER);
    cur_req = "R2";  wr_duty(301); wr_page(0);  run_clocks(3 * PER);
    cur_req = "R4";  wr_duty(300); wr_page(4);  run_clocks(3 * PER);
    cur_req = "R3";  wr_duty(1023); wr_page(8); run_clocks(3 * PER);
    cur_req = "R7";  wr_duty(517); wr_page(15); run_clocks(3 * PER);
    cur_req = "R7";  wr_page(10);  run_clocks(2 * PER);
    cur_req = "R6";  run_clocks(PER / 3); wr_duty(77); run_clocks(PER / 4); wr_page(2);
    run_clocks(3 * PER);
    cur_req = "R5";  wr_duty(640); wr_page(5); run_clocks(3 * PER);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(150000 * 10);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule